// File: doc/BRIEF.md
# Expiry-Counting Watchdog with Keyed Disable

This block is a memory-mapped watchdog fed by a countdown timer that it carries with it. Software writes a period into the timer together with an enable bit and, optionally, a bit that makes the timer reload itself after every expiry. Each expiry raises a pending flag that software can clear, and it can also drive an interrupt line. Separately, software configures the watchdog and issues a start command. From then on the watchdog counts timer expiries. On the fourth counted expiry it emits a one-cycle pulse on a system reset line and on a secondary reset line, each gated by its own configuration bit. It then halts until it is started again.

A stop command cannot be issued by accident. It is accepted only when a key write to a dedicated register came first, and each accepted stop uses up that key. A start command always clears the expiry count. Expiries that happen while the watchdog is stopped are not counted.

The bus is a simple single-cycle register port: one write per clock with write enable, and combinational read data while read enable is high. A 10 s timeout at a 125000 counts-per-second tick works out to a period of 312500 counts, since four expiries make one timeout.

Top module: `expiry_watchdog`

## Requirements
- R1: The address map is: timer reload at 0x00, timer status at 0x04, watchdog configuration at 0x10, command at 0x18, key at 0x1C. Reading the reload register returns the last value written. Reading the configuration returns bit 15 (secondary reset enable), bit 14 (system reset enable), bit 12 (interrupt enable) and bits 3:0 (source select), with every other bit zero. The command and key registers read as zero.
- R2: A reload write with bit 31 set and a nonzero period in bits 29:0 starts the timer. With bit 30 set, it expires every P cycles: the first expiry is P clock edges after the write edge. A reload write with bit 31 clear (for example 0) stops the timer.
- R3: With bit 30 of the reload clear, the timer expires once, P edges after the write, and then stays idle.
- R4: Every timer expiry sets status bit 30, which is visible in the cycle after the expiring edge. Writing 1 to status bit 30 clears the flag. An expiry in the same cycle as the clear wins.
- R5: irq_out equals the pending flag while configuration bit 12 is 1, and is 0 otherwise.
- R6: A command write with bit 0 set clears the expiry count and runs the watchdog. Only expiries on edges after the start edge are counted. Expiries are not counted while the watchdog is stopped, nor when the source select is nonzero.
- R7: The fourth counted expiry makes sys_rst_pulse high for exactly one cycle, if configuration bit 14 is set, and aux_rst_pulse likewise, if bit 15 is set. Each pulse appears in the cycle after the fourth expiring edge.
- R8: After the fourth expiry the watchdog halts and makes no further pulses until a new start command.
- R9: A command write with bit 1 set and bit 0 clear stops the watchdog only if the most recent key write carried 0xC45A in bits 15:0. A key write with any other value removes the unlock.
- R10: An accepted stop uses up the unlock, so a later stop needs a fresh key write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 32 | Read data, combinational, zero when bus_re is low |
| irq_out | output | 1 | Timer expiry interrupt |
| sys_rst_pulse | output | 1 | One-cycle system reset request |
| aux_rst_pulse | output | 1 | One-cycle secondary reset request |

## Verification
A register write takes effect at the edge on which bus_we is sampled. Read data is combinational, so the bench samples it one time step after driving the address at a falling edge. The pending flag and the interrupt rise in the cycle after the expiring edge, which is P edges after the reload write. The reset pulses appear in the cycle after the fourth counted expiry. The bench timestamps every write edge and every pulse with a free-running edge counter, computes the due cycle from the requirements (including the case where the start edge and an expiry edge coincide), and compares the timestamps exactly.

// File: rtl/wdg_pkg.sv
// Package wdg_pkg: register offsets, bit positions and shared types of the
// expiry-counting watchdog. Assumes a 32-bit data bus.
package wdg_pkg;
    localparam int BUS_W       = 32;
    // Offsets inside each 16-byte register space
    localparam int OFS_RELOAD  = 'h0;
    localparam int OFS_STATUS  = 'h4;
    localparam int OFS_CFG     = 'h0;
    localparam int OFS_CMD     = 'h8;
    localparam int OFS_KEY     = 'hC;
    // Bit positions
    localparam int RL_EN_BIT   = 31;
    localparam int RL_PER_BIT  = 30;
    localparam int ST_PEND_BIT = 30;
    localparam int CFG_IRQ_BIT = 12;
    localparam int CFG_SYS_BIT = 14;
    localparam int CFG_AUX_BIT = 15;
    localparam int CMD_RUN_BIT = 0;
    localparam int CMD_HLT_BIT = 1;
    localparam int SRC_W       = 4;
    localparam int KEY_W       = 16;

    typedef struct packed {
        logic             aux_en;
        logic             sys_en;
        logic             irq_en;
        logic [SRC_W-1:0] src;
    } wdg_cfg_t;

    typedef struct packed {
        logic reload;
        logic status;
        logic cfg;
        logic cmd;
        logic key;
    } wr_strobe_t;
endpackage

// File: rtl/wdg_bus_decode.sv
// Module wdg_bus_decode: turns the register bus into per-register write
// strobes and builds the combinational read data.
// Assumes ADDR_W >= 5: the timer space sits at 0, the watchdog space at
// 1 << (ADDR_W-1), and each space holds at most four word registers.
module wdg_bus_decode
    import wdg_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [BUS_W-1:0]  reload_q,
    input  logic              pending,
    input  wdg_cfg_t          cfg_q,
    output wr_strobe_t        wr,
    output logic [BUS_W-1:0]  bus_rdata
);
    localparam logic [ADDR_W-1:0] WDG_BASE = ADDR_W'(1) << (ADDR_W - 1);
    localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFS_RELOAD);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_CFG    = WDG_BASE | ADDR_W'(OFS_CFG);
    localparam logic [ADDR_W-1:0] A_CMD    = WDG_BASE | ADDR_W'(OFS_CMD);
    localparam logic [ADDR_W-1:0] A_KEY    = WDG_BASE | ADDR_W'(OFS_KEY);

    logic hit_reload, hit_status, hit_cfg, hit_cmd, hit_key;
    logic [BUS_W-1:0] status_word, cfg_word;

    // Address match per register
    always_comb begin
        hit_reload = (bus_addr == A_RELOAD);
        hit_status = (bus_addr == A_STATUS);
        hit_cfg    = (bus_addr == A_CFG);
        hit_cmd    = (bus_addr == A_CMD);
        hit_key    = (bus_addr == A_KEY);
    end

    // Write strobes
    always_comb begin
        wr.reload = bus_we && hit_reload;
        wr.status = bus_we && hit_status;
        wr.cfg    = bus_we && hit_cfg;
        wr.cmd    = bus_we && hit_cmd;
        wr.key    = bus_we && hit_key;
    end

    // Readable register images
    always_comb begin
        status_word              = '0;
        status_word[ST_PEND_BIT] = pending;
        cfg_word                 = '0;
        cfg_word[CFG_AUX_BIT]    = cfg_q.aux_en;
        cfg_word[CFG_SYS_BIT]    = cfg_q.sys_en;
        cfg_word[CFG_IRQ_BIT]    = cfg_q.irq_en;
        cfg_word[SRC_W-1:0]      = cfg_q.src;
    end

    // Read multiplexer, zero when not reading or unmapped
    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            if (hit_reload)      bus_rdata = reload_q;
            else if (hit_status) bus_rdata = status_word;
            else if (hit_cfg)    bus_rdata = cfg_word;
        end
    end
endmodule

// File: rtl/wdg_tick_timer.sv
// Module wdg_tick_timer: countdown timer with reload register, one-shot or
// periodic mode, and a sticky pending flag. It counts one per clock.
// Assumes PERIOD_W <= 30, so the period field stays clear of the mode bits.
module wdg_tick_timer
    import wdg_pkg::*;
#(
    parameter int PERIOD_W = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_reload,
    input  logic [BUS_W-1:0] wdata,
    input  logic             clr_pend,
    output logic [BUS_W-1:0] reload_q,
    output logic             expire,
    output logic             pending
);
    logic [PERIOD_W-1:0] cnt_q;
    logic [PERIOD_W-1:0] period;
    logic [PERIOD_W-1:0] new_period;
    logic                active_q;

    assign period     = reload_q[PERIOD_W-1:0];
    assign new_period = wdata[PERIOD_W-1:0];
    assign expire     = active_q && (cnt_q == PERIOD_W'(1));

    // Reload register storage
    always_ff @(posedge clk) begin
        if (!rst_n)         reload_q <= '0;
        else if (wr_reload) reload_q <= wdata;
    end

    // Countdown and run state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (wr_reload) begin
            active_q <= wdata[RL_EN_BIT] && (new_period != '0);
            cnt_q    <= new_period;
        end else if (expire) begin
            cnt_q <= period;
            if (!reload_q[RL_PER_BIT]) active_q <= 1'b0;
        end else if (active_q) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Pending flag: an expiry wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n)        pending <= 1'b0;
        else if (expire)   pending <= 1'b1;
        else if (clr_pend) pending <= 1'b0;
    end
endmodule

// File: rtl/wdg_expiry_ctrl.sv
// Module wdg_expiry_ctrl: watchdog configuration, run state, expiry counter,
// key-guarded stop and the gated one-cycle reset pulses.
// Assumes at most one register write per cycle and that expire is a
// one-cycle strobe.
module wdg_expiry_ctrl
    import wdg_pkg::*;
#(
    parameter int               LIMIT = 4,
    parameter logic [KEY_W-1:0] KEY   = 16'hC45A,
    localparam int              EXP_W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cfg,
    input  wdg_cfg_t         cfg_in,
    input  logic             wr_cmd,
    input  logic [1:0]       cmd_bits,
    input  logic             wr_key,
    input  logic [KEY_W-1:0] key_in,
    input  logic             expire,
    output wdg_cfg_t         cfg_q,
    output logic             running,
    output logic [EXP_W-1:0] exp_cnt,
    output logic             unlocked,
    output logic             sys_rst_pulse,
    output logic             aux_rst_pulse
);
    logic start_cmd, stop_cmd, counted, fire, src_ok;

    // Command decode and expiry qualification
    always_comb begin
        src_ok    = (cfg_q.src == '0);
        start_cmd = wr_cmd && cmd_bits[CMD_RUN_BIT];
        stop_cmd  = wr_cmd && cmd_bits[CMD_HLT_BIT] && !cmd_bits[CMD_RUN_BIT] && unlocked;
        counted   = running && expire && src_ok && !start_cmd && !stop_cmd;
        fire      = counted && (exp_cnt == EXP_W'(LIMIT - 1));
    end

    // Configuration register
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (wr_cfg) cfg_q <= cfg_in;
    end

    // Run state: start beats stop, the final expiry halts
    always_ff @(posedge clk) begin
        if (!rst_n)         running <= 1'b0;
        else if (start_cmd) running <= 1'b1;
        else if (stop_cmd)  running <= 1'b0;
        else if (fire)      running <= 1'b0;
    end

    // Expiry counter
    always_ff @(posedge clk) begin
        if (!rst_n)         exp_cnt <= '0;
        else if (start_cmd) exp_cnt <= '0;
        else if (fire)      exp_cnt <= '0;
        else if (counted)   exp_cnt <= exp_cnt + 1'b1;
    end

    // Unlock state: set by the right key, used up by an accepted stop
    always_ff @(posedge clk) begin
        if (!rst_n)        unlocked <= 1'b0;
        else if (stop_cmd) unlocked <= 1'b0;
        else if (wr_key)   unlocked <= (key_in == KEY);
    end

    // Registered reset pulses, each behind its own enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sys_rst_pulse <= 1'b0;
            aux_rst_pulse <= 1'b0;
        end else begin
            sys_rst_pulse <= fire && cfg_q.sys_en;
            aux_rst_pulse <= fire && cfg_q.aux_en;
        end
    end
endmodule

// File: rtl/expiry_watchdog.sv
// Module expiry_watchdog: top level. Connects the bus decoder, the countdown
// timer and the watchdog controller. Assumes a single clock domain and a
// synchronous active-low reset.
module expiry_watchdog
    import wdg_pkg::*;
#(
    parameter int               ADDR_W       = 5,
    parameter int               PERIOD_W     = 30,
    parameter int               EXPIRY_LIMIT = 4,
    parameter logic [KEY_W-1:0] UNLOCK_KEY   = 16'hC45A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq_out,
    output logic              sys_rst_pulse,
    output logic              aux_rst_pulse
);
    localparam int EXP_W = (EXPIRY_LIMIT > 1) ? $clog2(EXPIRY_LIMIT) : 1;

    wr_strobe_t       wr;
    logic [BUS_W-1:0] reload_q;
    logic             expire;
    logic             pending;
    wdg_cfg_t         cfg_in;
    wdg_cfg_t         cfg_q;
    logic             running;
    logic             unlocked;
    logic [EXP_W-1:0] exp_cnt;

    // Configuration fields taken from the write data
    always_comb begin
        cfg_in.aux_en = bus_wdata[CFG_AUX_BIT];
        cfg_in.sys_en = bus_wdata[CFG_SYS_BIT];
        cfg_in.irq_en = bus_wdata[CFG_IRQ_BIT];
        cfg_in.src    = bus_wdata[SRC_W-1:0];
    end

    // Interrupt follows pending while enabled
    assign irq_out = pending && cfg_q.irq_en;

    wdg_bus_decode #(.ADDR_W(ADDR_W)) dec_i (
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_re   (bus_re),
        .reload_q (reload_q),
        .pending  (pending),
        .cfg_q    (cfg_q),
        .wr       (wr),
        .bus_rdata(bus_rdata)
    );

    wdg_tick_timer #(.PERIOD_W(PERIOD_W)) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_reload(wr.reload),
        .wdata    (bus_wdata),
        .clr_pend (wr.status && bus_wdata[ST_PEND_BIT]),
        .reload_q (reload_q),
        .expire   (expire),
        .pending  (pending)
    );

    wdg_expiry_ctrl #(.LIMIT(EXPIRY_LIMIT), .KEY(UNLOCK_KEY)) ctl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_cfg       (wr.cfg),
        .cfg_in       (cfg_in),
        .wr_cmd       (wr.cmd),
        .cmd_bits     (bus_wdata[1:0]),
        .wr_key       (wr.key),
        .key_in       (bus_wdata[KEY_W-1:0]),
        .expire       (expire),
        .cfg_q        (cfg_q),
        .running      (running),
        .exp_cnt      (exp_cnt),
        .unlocked     (unlocked),
        .sys_rst_pulse(sys_rst_pulse),
        .aux_rst_pulse(aux_rst_pulse)
    );
endmodule

// File: rtl/wdg_checker.sv
// Module wdg_checker: temporal properties of the watchdog, bound to
// expiry_watchdog. Observes only; drives nothing.
module wdg_checker #(
    parameter int EXP_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_cmd,
    input logic [1:0]       cmd_bits,
    input logic             unlocked,
    input logic             expire,
    input logic             pending,
    input logic             irq_out,
    input logic             running,
    input logic [EXP_W-1:0] exp_cnt,
    input logic             cfg_sys_en,
    input logic             sys_rst_pulse,
    input logic             aux_rst_pulse
);
    // R4
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> pending);
    // R5
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> pending);
    // R6
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && cmd_bits[0]) |=> (running && exp_cnt == '0));
    // R7
    sys_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_pulse |=> !sys_rst_pulse);
    // R7
    aux_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aux_rst_pulse |=> !aux_rst_pulse);
    // R7
    sys_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_pulse |-> $past(cfg_sys_en));
    // R8
    halt_after_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst_pulse || aux_rst_pulse) |-> !running);
    // R9
    locked_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && cmd_bits == 2'b10 && !unlocked && !expire) |=> (running == $past(running)));
endmodule

bind expiry_watchdog wdg_checker #(.EXP_W(EXP_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_cmd       (wr.cmd),
    .cmd_bits     (bus_wdata[1:0]),
    .unlocked     (unlocked),
    .expire       (expire),
    .pending      (pending),
    .irq_out      (irq_out),
    .running      (running),
    .exp_cnt      (exp_cnt),
    .cfg_sys_en   (cfg_q.sys_en),
    .sys_rst_pulse(sys_rst_pulse),
    .aux_rst_pulse(aux_rst_pulse)
);

// File: tb/expiry_watchdog_tb.sv
// Directed bench for expiry_watchdog: one task per scenario.
module expiry_watchdog_tb_top;
    localparam int P = 5;
    localparam logic [4:0] A_RELOAD = 5'h00, A_STATUS = 5'h04, A_CFG = 5'h10,
                           A_CMD = 5'h18, A_KEY = 5'h1C;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_we, bus_re;
    logic [31:0] bus_rdata;
    logic        irq_out, sys_rst_pulse, aux_rst_pulse;

    int checks = 0, errors = 0, cyc = 0;
    int sys_n = 0, aux_n = 0, sys_at = -1, aux_at = -1, last_wr = 0;
    bit timeout = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Timestamp every reset pulse
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (sys_rst_pulse) begin sys_n++; sys_at = cyc; end
            if (aux_rst_pulse) begin aux_n++; aux_at = cyc; end
        end
    end

    expiry_watchdog dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .irq_out(irq_out), .sys_rst_pulse(sys_rst_pulse), .aux_rst_pulse(aux_rst_pulse)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bus_we = 1'b0; bus_re = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        sys_n = 0; aux_n = 0; sys_at = -1; aux_at = -1;
    endtask

    // Called at a falling edge; returns at the falling edge after the write edge
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
        last_wr = cyc;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a; bus_re = 1'b1;
        #1;
        d = bus_rdata;
        bus_re = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        rd(A_RELOAD, d); chk("R1", "reload after reset", d, 0);
        rd(A_STATUS, d); chk("R4", "status after reset", d, 0);
        rd(A_CFG, d);    chk("R1", "cfg after reset", d, 0);
        chk("R5", "irq after reset", irq_out, 0);
        chk("R7", "pulses after reset", sys_rst_pulse | aux_rst_pulse, 0);
    endtask

    task automatic t_readback();
        logic [31:0] d;
        do_reset();
        wr(A_RELOAD, 32'h4000_0010);
        rd(A_RELOAD, d); chk("R1", "reload readback", d, 32'h4000_0010);
        wr(A_CFG, 32'hFFFF_FFFF);
        rd(A_CFG, d);    chk("R1", "cfg readback", d, 32'h0000_D00F);
        rd(A_CMD, d);    chk("R1", "cmd reads zero", d, 0);
        rd(A_KEY, d);    chk("R1", "key reads zero", d, 0);
    endtask

    task automatic t_fourth();
        logic [31:0] d;
        int l;
        do_reset();
        wr(A_CFG, 32'h0000_C000);
        wr(A_CMD, 32'h1);
        wr(A_RELOAD, 32'hC000_0000 | P); l = last_wr;
        idle(4 * P + 3);
        chk("R7", "sys pulse count", sys_n, 1);
        chk("R7", "sys pulse cycle", sys_at, l + 4 * P);
        chk("R7", "aux pulse cycle", aux_at, l + 4 * P);
        rd(A_STATUS, d); chk("R4", "pending set", d, 32'h4000_0000);
        chk("R5", "irq masked", irq_out, 0);
        idle(6 * P);
        chk("R8", "no pulse after halt", sys_n, 1);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        int l;
        do_reset();
        wr(A_CFG, 32'h0000_1000);
        wr(A_RELOAD, 32'hC000_0000 | P); l = last_wr;
        idle(P - 1);
        chk("R2", "irq before first expiry", irq_out, 0);
        idle(1);
        chk("R2", "irq at first expiry", irq_out, 1);
        rd(A_STATUS, d); chk("R4", "pending at expiry", d, 32'h4000_0000);
        wr(A_RELOAD, 32'h0);
        wr(A_STATUS, 32'h4000_0000);
        rd(A_STATUS, d); chk("R4", "pending cleared", d, 0);
        chk("R5", "irq follows clear", irq_out, 0);
        idle(4 * P);
        rd(A_STATUS, d); chk("R2", "stopped timer stays quiet", d, 0);
    endtask

    task automatic t_oneshot();
        logic [31:0] d;
        do_reset();
        wr(A_CFG, 32'h0000_C000);
        wr(A_CMD, 32'h1);
        wr(A_RELOAD, 32'h8000_0000 | P);
        idle(P + 2);
        rd(A_STATUS, d); chk("R3", "one-shot expired", d, 32'h4000_0000);
        wr(A_STATUS, 32'h4000_0000);
        idle(6 * P);
        rd(A_STATUS, d); chk("R3", "no second expiry", d, 0);
        chk("R3", "no reset from one-shot", sys_n, 0);
    endtask

    task automatic t_stop(input string req, input logic [31:0] key, input bit use_key, input bit restart, input int exp_n);
        int l;
        do_reset();
        wr(A_CFG, 32'h0000_C000);
        wr(A_CMD, 32'h1);
        if (use_key) wr(A_KEY, key);
        wr(A_CMD, 32'h2);
        if (restart) begin
            wr(A_CMD, 32'h1);
            wr(A_CMD, 32'h2);
        end
        wr(A_RELOAD, 32'hC000_0000 | P); l = last_wr;
        idle(6 * P);
        chk(req, "pulse count", sys_n, exp_n);
        if (exp_n == 1) chk(req, "pulse cycle", sys_at, l + 4 * P);
    endtask

    task automatic t_gate();
        do_reset();
        wr(A_CFG, 32'h0000_4000);
        wr(A_CMD, 32'h1);
        wr(A_RELOAD, 32'hC000_0000 | P);
        idle(4 * P + 3);
        chk("R7", "sys enabled fires", sys_n, 1);
        chk("R7", "aux disabled silent", aux_n, 0);
    endtask

    task automatic t_src();
        do_reset();
        wr(A_CFG, 32'h0000_C001);
        wr(A_CMD, 32'h1);
        wr(A_RELOAD, 32'hC000_0000 | P);
        idle(6 * P);
        chk("R6", "nonzero source ignores timer", sys_n, 0);
    endtask

    // Start lands `gap` edges after the load; expected due cycle is computed
    task automatic t_late_start(input int gap);
        int l, s, k, due;
        do_reset();
        wr(A_CFG, 32'h0000_C000);
        wr(A_RELOAD, 32'hC000_0000 | P); l = last_wr;
        idle(gap - 1);
        wr(A_CMD, 32'h1); s = last_wr;
        chk("R6", "no count while stopped", sys_n, 0);
        k = (s - l) / P + 1;
        due = l + (k + 3) * P;
        idle(due + 2 - cyc);
        chk("R6", "count from start edge", sys_at, due);
        wr(A_CMD, 32'h1); s = last_wr;
        k = (s - l) / P + 1;
        due = l + (k + 3) * P;
        idle(due + 2 - cyc);
        chk("R8", "restart after halt", sys_n, 2);
        chk("R8", "restart pulse cycle", sys_at, due);
    endtask

    task automatic run_all();
        t_reset();
        t_readback();
        t_fourth();
        t_irq();
        t_oneshot();
        t_stop("R9", 32'h0, 1'b0, 1'b0, 1);
        t_stop("R9", 32'h0000_C45B, 1'b1, 1'b0, 1);
        t_stop("R9", 32'h0000_C45A, 1'b1, 1'b0, 0);
        t_stop("R10", 32'h0000_C45A, 1'b1, 1'b1, 1);
        t_gate();
        t_src();
        t_late_start(12);
        t_late_start(10);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                timeout = 1;
            end
        join_any
        disable fork;
        if (timeout) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule